// File: doc/BRIEF.md
# Per-CPU Masked Device Interrupt Router

This block gathers a vector of level-sensitive device interrupt lines into one shared raw request register and hands a filtered view of it to each of several processors. Every processor owns a full-width enable mask; its interrupt output is raised whenever at least one source that its mask lets through is high. The raw vector, the per-processor masks and the per-processor filtered views all sit on a simple 8-byte control/status port at fixed offsets, so software can find out which source fired by reading its own view. No priority encoding or vectoring happens here.

A cascaded legacy interrupt controller has one dedicated input that is merged onto source line 55. Source levels pass through one capture register before they reach the raw register, so the processor outputs come only from registered state and never glitch.

Top module: `irq_route_top`

## Requirements
- R1: Raw request bit n equals the level source n had two rising clock edges earlier (one capture stage, then the raw register); the raw vector is read at offset 0x300.
- R2: The mask registers sit at offsets 0x200 (CPU 0), 0x240 (CPU 1), 0x600 (CPU 2) and 0x640 (CPU 3); a write loads all 64 bits and a read returns the stored value in the same cycle.
- R3: A write to one CPU's mask offset leaves the masks of all other CPUs unchanged.
- R4: The filtered view at 0x280 (CPU 0), 0x2C0 (CPU 1), 0x680 (CPU 2) and 0x6C0 (CPU 3) reads as the raw vector ANDed with that CPU's mask.
- R5: Writes to the view offsets and to the raw offset change no register: masks, views and raw reads stay as before.
- R6: Output irq_o[c] is high exactly when the raw vector ANDed with the mask of CPU c is non-zero, updated on the same edge that changes either register.
- R7: The legacy controller input is ORed into source line 55 and follows the same two-edge path as R1.
- R8: A read of an unassigned offset, or of any offset whose low three bits are not zero, returns all ones; a write there changes nothing.
- R9: After reset all masks and the raw vector are zero and every irq_o bit is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_lvl_i | input | 64 | Device interrupt source levels |
| legacy_irq_i | input | 1 | Cascaded legacy controller output, merged onto line 55 |
| csr_req_i | input | 1 | Register access strobe |
| csr_we_i | input | 1 | 1 = write, 0 = read |
| csr_addr_i | input | 12 | Byte offset of the 8-byte register |
| csr_wdata_i | input | 64 | Write data |
| csr_rdata_o | output | 64 | Read data, valid in the cycle of a read strobe |
| irq_o | output | 4 | One interrupt request per CPU |

## Verification
The bench builds the router with its defaults: 64 source lines, four CPUs and a 12-bit offset, which puts every mask and view slot of the split map (both the low pair near 0x200 and the high pair near 0x600) within reach, together with line 55 for the legacy merge and the top line 63. Directed scenarios walk sparse and dense source patterns against disjoint and overlapping masks, then poke the read-only and unassigned offsets and misaligned addresses to show that nothing moves.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned OFF_RAW    = 12'h300;
  localparam int unsigned OFF_VIEW_D = 12'h080;

  // CPUs 0 and 1 live in the low bank, 2 and 3 in the high bank.
  function automatic int unsigned mask_off(input int unsigned cpu);
    if (cpu < 2) return 12'h200 + 12'h040 * cpu;
    else         return 12'h600 + 12'h040 * (cpu - 2);
  endfunction

  function automatic int unsigned view_off(input int unsigned cpu);
    return mask_off(cpu) + OFF_VIEW_D;
  endfunction
endpackage

// File: rtl/irq_src_capture.sv
module irq_src_capture #(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] lvl_i,
  output logic [NUM_SRC-1:0] raw_o
);
  logic [NUM_SRC-1:0] stage_q, stage_d;
  logic [NUM_SRC-1:0] raw_q, raw_d;

  always_comb begin
    stage_d = lvl_i;
    raw_d   = stage_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      raw_q   <= '0;
    end else begin
      stage_q <= stage_d;
      raw_q   <= raw_d;
    end
  end

  assign raw_o = raw_q;

  // R1: raw register takes the captured level one edge later
  p_raw_follows_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_q == $past(stage_q));
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned WIDTH   = 64,
  parameter int unsigned ADDR_W  = 12
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [WIDTH-1:0]              wdata_i,
  output logic [NUM_CPU-1:0][WIDTH-1:0] mask_o
);
  logic [NUM_CPU-1:0][WIDTH-1:0] mask_q, mask_d;
  logic [NUM_CPU-1:0]            wen;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    localparam logic [ADDR_W-1:0] MOFF = ADDR_W'(mask_off(c));
    assign wen[c] = wr_i && (addr_i == MOFF);

    always_comb begin
      mask_d[c] = mask_q[c];
      if (wen[c]) mask_d[c] = wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     mask_q[c] <= '0;
      else if (wen[c]) mask_q[c] <= mask_d[c];
    end

    // R3: only a write at this CPU's own offset may alter its mask
    p_mask_isolated_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_i && addr_i == MOFF) |=> $stable(mask_q[c]));
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_csr_read.sv
module irq_csr_read
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned WIDTH   = 64,
  parameter int unsigned ADDR_W  = 12
) (
  input  logic                          rd_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [WIDTH-1:0]              raw_i,
  input  logic [NUM_CPU-1:0][WIDTH-1:0] mask_i,
  output logic [WIDTH-1:0]              rdata_o
);
  logic aligned;
  assign aligned = (addr_i[2:0] == 3'b000);

  always_comb begin
    rdata_o = '1;
    if (aligned) begin
      if (addr_i == ADDR_W'(OFF_RAW)) rdata_o = raw_i;
      for (int unsigned c = 0; c < NUM_CPU; c++) begin
        if (addr_i == ADDR_W'(mask_off(c))) rdata_o = mask_i[c];
        if (addr_i == ADDR_W'(view_off(c))) rdata_o = raw_i & mask_i[c];
      end
    end
    if (!rd_i) rdata_o = '0;
  end
endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 64,
  parameter int unsigned NUM_CPU     = 4,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned LEGACY_LINE = 55
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_lvl_i,
  input  logic               legacy_irq_i,
  input  logic               csr_req_i,
  input  logic               csr_we_i,
  input  logic [ADDR_W-1:0]  csr_addr_i,
  input  logic [NUM_SRC-1:0] csr_wdata_i,
  output logic [NUM_SRC-1:0] csr_rdata_o,
  output logic [NUM_CPU-1:0] irq_o
);
  localparam logic [NUM_SRC-1:0] LEGACY_BIT = NUM_SRC'(1) << LEGACY_LINE;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic [NUM_SRC-1:0]              src_merged;
  logic [NUM_SRC-1:0]              raw;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] mask;
  logic                            wr_aligned;

  assign src_merged = src_lvl_i | (legacy_irq_i ? LEGACY_BIT : '0);
  assign wr_aligned = csr_req_i && csr_we_i && (csr_addr_i[2:0] == 3'b000);

  irq_src_capture #(.NUM_SRC(NUM_SRC)) u_capture (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .lvl_i (src_merged),
    .raw_o (raw)
  );

  irq_mask_bank #(.NUM_CPU(NUM_CPU), .WIDTH(NUM_SRC), .ADDR_W(ADDR_W)) u_masks (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .wr_i   (wr_aligned),
    .addr_i (csr_addr_i),
    .wdata_i(csr_wdata_i),
    .mask_o (mask)
  );

  irq_csr_read #(.NUM_CPU(NUM_CPU), .WIDTH(NUM_SRC), .ADDR_W(ADDR_W)) u_read (
    .rd_i   (csr_req_i && !csr_we_i),
    .addr_i (csr_addr_i),
    .raw_i  (raw),
    .mask_i (mask),
    .rdata_o(csr_rdata_o)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_irq
    assign irq_o[c] = |(raw & mask[c]);

    // R6: an all-zero mask can never raise this CPU's request
    p_no_irq_unmasked_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
      (mask[c] == '0) |-> !irq_o[c]);
  end

  // assertion-only age counter since reset release
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)              age_q <= 2'd0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  // R5: writes to view or raw offsets leave every mask alone
  p_ro_write_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (csr_req_i && csr_we_i && (csr_addr_i == ADDR_W'(OFF_RAW) ||
      csr_addr_i == ADDR_W'(view_off(0)))) |=> $stable(mask));

  // R8: misaligned reads return all ones
  p_misaligned_read_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (csr_req_i && !csr_we_i && csr_addr_i[2:0] != 3'b000) |-> (csr_rdata_o == '1));

  // R7: legacy input reaches line 55 two edges later
  p_legacy_line_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (age_q == 2'd3 && $past(legacy_irq_i, 2)) |-> raw[LEGACY_LINE]);
endmodule

// File: tb/irq_route_top_bench.sv
module irq_route_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 64;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] src;
  logic          legacy;
  logic          req, we;
  logic [11:0]   addr;
  logic [NS-1:0] wdata, rdata;
  logic [NC-1:0] irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_route_top u_irq_route_top (
    .clk_i(clk), .rst_ni(rst_n), .src_lvl_i(src), .legacy_irq_i(legacy),
    .csr_req_i(req), .csr_we_i(we), .csr_addr_i(addr), .csr_wdata_i(wdata),
    .csr_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [11:0] moff(int c);
    return (c < 2) ? 12'(12'h200 + 12'h40 * c) : 12'(12'h600 + 12'h40 * (c - 2));
  endfunction
  function automatic logic [11:0] voff(int c);
    return moff(c) + 12'h080;
  endfunction

  task automatic check(string req_id, logic [NS-1:0] act, logic [NS-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req_id, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [NS-1:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [NS-1:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  // sources settle through two edges
  task automatic drive_src(logic [NS-1:0] s, logic leg);
    @(negedge clk);
    src = s; legacy = leg;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [NS-1:0] d;
    rd(12'h300, d); check("R9 raw", d, '0);
    for (int c = 0; c < NC; c++) begin
      rd(moff(c), d); check("R9 mask", d, '0);
    end
    check("R9 irq", NS'(irq), '0);
  endtask

  task automatic t_raw_follow();
    logic [NS-1:0] d;
    logic [NS-1:0] p = 64'h8000_0000_0000_0001;
    @(negedge clk); src = p;
    @(negedge clk);
    rd(12'h300, d); check("R1 one edge", d, '0);
    @(negedge clk);
    rd(12'h300, d); check("R1 two edges", d, p);
    drive_src(64'hA5A5_0000_FFFF_0F0F, 1'b0);
    rd(12'h300, d); check("R1 dense", d, 64'hA5A5_0000_FFFF_0F0F);
  endtask

  task automatic t_masks();
    logic [NS-1:0] d;
    for (int c = 0; c < NC; c++) wr(moff(c), 64'h1111_0000_0000_0000 << c);
    for (int c = 0; c < NC; c++) begin
      rd(moff(c), d); check("R2 readback", d, 64'h1111_0000_0000_0000 << c);
    end
    wr(moff(1), 64'hDEAD_BEEF_0000_0001);
    rd(moff(0), d); check("R3 cpu0", d, 64'h1111_0000_0000_0000);
    rd(moff(2), d); check("R3 cpu2", d, 64'h1111_0000_0000_0000 << 2);
    rd(moff(3), d); check("R3 cpu3", d, 64'h1111_0000_0000_0000 << 3);
    rd(moff(1), d); check("R2 cpu1", d, 64'hDEAD_BEEF_0000_0001);
  endtask

  task automatic t_views_irq();
    logic [NS-1:0] d;
    logic [NS-1:0] m [NC];
    logic [NS-1:0] s = 64'h0000_00F0_0000_0003;
    m[0] = 64'h1; m[1] = 64'h2; m[2] = 64'h0000_00FF_0000_0000; m[3] = 64'h4;
    for (int c = 0; c < NC; c++) wr(moff(c), m[c]);
    drive_src(s, 1'b0);
    for (int c = 0; c < NC; c++) begin
      rd(voff(c), d); check("R4 view", d, s & m[c]);
    end
    check("R6 irq", NS'(irq), NS'(4'b0111));
    // mask change alone updates irq on the write edge
    @(negedge clk); req = 1'b1; we = 1'b1; addr = moff(3); wdata = 64'h1;
    @(negedge clk); req = 1'b0; we = 1'b0;
    check("R6 mask edge", NS'(irq), NS'(4'b1111));
    // source drop clears after two edges
    drive_src('0, 1'b0);
    check("R6 drop", NS'(irq), '0);
  endtask

  task automatic t_ro_writes();
    logic [NS-1:0] d;
    wr(moff(0), 64'hFF);
    drive_src(64'h0F, 1'b0);
    wr(voff(0), '1);
    wr(12'h300, '1);
    rd(moff(0), d); check("R5 mask kept", d, 64'hFF);
    rd(voff(0), d); check("R5 view kept", d, 64'h0F);
    rd(12'h300, d); check("R5 raw kept", d, 64'h0F);
  endtask

  task automatic t_unassigned();
    logic [NS-1:0] d;
    rd(12'h100, d); check("R8 unassigned", d, '1);
    rd(12'h204, d); check("R8 misaligned", d, '1);
    wr(12'h201, 64'h0);
    rd(moff(0), d); check("R8 write ignored", d, 64'hFF);
    wr(12'h7F8, 64'h0);
    rd(moff(0), d); check("R8 write ignored hi", d, 64'hFF);
  endtask

  task automatic t_legacy();
    logic [NS-1:0] d;
    wr(moff(2), 64'h1 << 55);
    drive_src('0, 1'b1);
    rd(12'h300, d); check("R7 line55", d, 64'h1 << 55);
    check("R7 irq2", NS'(irq[2]), NS'(1));
    drive_src(64'h1 << 55, 1'b0);
    rd(12'h300, d); check("R7 or src", d, 64'h1 << 55);
    drive_src('0, 1'b0);
    check("R7 clear", NS'(irq[2]), '0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src = '0; legacy = 1'b0;
    req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_raw_follow();
    t_masks();
    t_views_irq();
    t_ro_writes();
    t_unassigned();
    t_legacy();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule